// File: doc/BRIEF.md
# Sixteen-Bit Capture Timer with Mode-Selected Edge Pairs

This block is a 16-bit up-counter for event timing and pulse measurement. A byte-wide mode register picks the count source. It also decides whether a compare match sends the counter back to zero, and which pair of input edges copies the running count into two capture registers. The same register offers a software-triggered capture and can make an output flip-flop invert on capture or on compare match. A separate run bit starts and stops counting. The compare value and the count and capture values are reached as bytes over a simple synchronous register bus.

Two external pins and a trigger line from a neighbouring timer feed the capture logic. Each of them passes through a two-flop synchronizer and an edge detector, so every edge the logic sees lasts one clock cycle. Three prescaler ticks (divide by 1, 4 and 16) come from outside the block. The block drives the toggle flip-flop output, a one-cycle match flag and an interrupt pulse taken from external input 0.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset the mode register (address 0) reads 0x20, the run register (address 1, bit 0) reads 0, count and both capture registers read 0, and the toggle output is 0. Mode bit 5 always reads 1. The mode fields are: [1:0] count source, [2] clear on match, [4:3] capture mode, [5] software capture (write 0 to fire), [6] invert on match, [7] invert on capture register 1 load. The byte addresses are: compare 2 (low) and 3 (high), count 4 and 5, capture register 0 at 6 and 7, capture register 1 at 8 and 9.
- R2: The count source code selects the increment condition. 00 counts synchronized rising edges of external input 0, 01 counts cycles with the divide-by-1 tick high, 10 the divide-by-4 tick, and 11 the divide-by-16 tick. A tick that is not selected has no effect on the count.
- R3: While the run bit is 0 the count holds its value, whatever the ticks do.
- R4: With clear-on-match set, a counting step taken while the count equals the compare value loads 0, so the counter repeats with a period of compare+1 steps.
- R5: A counting step taken while the count equals the compare value drives match_pulse high for exactly one cycle, in the cycle after that step. This happens whether or not clear is enabled. With clear disabled the count continues to compare+1.
- R6: Capture mode 01 loads capture register 0 on a rising edge of external input 0 and capture register 1 on a rising edge of external input 1. Falling edges load nothing.
- R7: Capture mode 10 loads capture register 0 on a rising edge of input 0, and capture register 1 on the next falling edge of input 0. External input 1 is ignored.
- R8: Capture mode 11 loads capture register 0 on a rising edge of the neighbour trigger and capture register 1 on its falling edge. External input 0 edges load nothing.
- R9: The interrupt output pulses once for each falling edge of input 0 in capture mode 10. In every other capture mode, including 00, it pulses once for each rising edge of input 0.
- R10: A mode write with bit 5 at 0 copies the current count into capture register 0 at that write. A mode write with bit 5 at 1 leaves capture register 0 unchanged.
- R11: The toggle output inverts on every capture register 1 load while mode bit 7 is 1, and on every match while mode bit 6 is 1. When both events fall in one cycle it inverts once.
- R12: Capture mode 00 loads neither capture register from any input edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rdata | output | 8 | Read data for addr, combinational |
| ext_in0 | input | 1 | External capture, clock and interrupt input 0 (asynchronous) |
| ext_in1 | input | 1 | External capture input 1 (asynchronous) |
| nbr_trig | input | 1 | Trigger from neighbouring timer (asynchronous) |
| tick_div1 | input | 1 | Prescaler tick, divide by 1 |
| tick_div4 | input | 1 | Prescaler tick, divide by 4 |
| tick_div16 | input | 1 | Prescaler tick, divide by 16 |
| ff_out | output | 1 | Toggle flip-flop |
| match_pulse | output | 1 | One-cycle compare match flag |
| ext_irq | output | 1 | One-cycle external-edge interrupt |

## Verification
The checker verifies several properties on every cycle: a stopped counter holds still, a match with clear enabled leaves the count at zero, a match without clear leaves the count one above its previous value, a capture register 1 load holds the count from the cycle before, every inversion of the toggle output traces back to an enabled match or capture, and mode bit 5 reads as 1. The directed scenarios cover what depends on input edge patterns and mode choice. These are the edge pair each capture mode selects, the pairing of rise and fall in pulse-width mode, which edge raises the interrupt, the choice of count source, the match period, and the software capture write.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SRC_EXT0  = 2'b00,
    SRC_DIV1  = 2'b01,
    SRC_DIV4  = 2'b10,
    SRC_DIV16 = 2'b11
  } clk_src_e;

  typedef enum logic [1:0] {
    CAP_OFF       = 2'b00,
    CAP_TWO_PIN   = 2'b01,
    CAP_PULSE     = 2'b10,
    CAP_NEIGHBOUR = 2'b11
  } cap_mode_e;

  typedef struct packed {
    logic      tog_on_cap1;
    logic      tog_on_match;
    logic      sw_cap_n;
    cap_mode_e cap_mode;
    logic      clr_on_match;
    clk_src_e  clk_src;
  } mode_t;

  localparam logic [BYTE_W-1:0] MODE_RESET = 8'h20;
endpackage

// File: rtl/tmr_edge_sync.sv
`timescale 1ns/1ps
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign chain_d[g] = async_in;
      end else begin : g_next
        assign chain_d[g] = chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;
endmodule

// File: rtl/tmr_count_core.sv
`timescale 1ns/1ps
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  clk_src_e         src,
  input  logic             clr_on_match,
  input  logic [CNT_W-1:0] cmp,
  input  logic             tick_div1,
  input  logic             tick_div4,
  input  logic             tick_div16,
  input  logic             ext0_rise,
  output logic [CNT_W-1:0] count,
  output logic             match_evt,
  output logic             match_pulse
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             match_q;
  logic             src_tick;
  logic             cnt_en;

  always_comb begin
    unique case (src)
      SRC_EXT0:  src_tick = ext0_rise;
      SRC_DIV1:  src_tick = tick_div1;
      SRC_DIV4:  src_tick = tick_div4;
      SRC_DIV16: src_tick = tick_div16;
      default:   src_tick = 1'b0;
    endcase
  end

  assign cnt_en    = run & src_tick;
  assign match_evt = cnt_en && (count_q == cmp);

  always_comb begin
    count_d = count_q;
    if (cnt_en) begin
      if (match_evt && clr_on_match) count_d = '0;
      else                           count_d = count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      match_q <= 1'b0;
    end else begin
      count_q <= count_d;
      match_q <= match_evt;
    end
  end

  assign count       = count_q;
  assign match_pulse = match_q;
endmodule

// File: rtl/tmr_capture.sv
`timescale 1ns/1ps
module tmr_capture
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cap_mode_e        mode,
  input  logic             tog_on_cap1,
  input  logic             tog_on_match,
  input  logic             sw_cap,
  input  logic [CNT_W-1:0] count,
  input  logic             in0_rise,
  input  logic             in0_fall,
  input  logic             in1_rise,
  input  logic             nb_rise,
  input  logic             nb_fall,
  input  logic             match_evt,
  output logic [CNT_W-1:0] cap0,
  output logic [CNT_W-1:0] cap1,
  output logic             cap1_ld,
  output logic             ff_out,
  output logic             irq
);
  logic [CNT_W-1:0] cap0_q, cap0_d, cap1_q, cap1_d;
  logic             arm_q, arm_d;
  logic             ff_q, ff_d;
  logic             irq_q, irq_d;
  logic             cap0_ld;
  logic             inv_req;

  always_comb begin
    cap0_ld = sw_cap;
    cap1_ld = 1'b0;
    arm_d   = 1'b0;
    unique case (mode)
      CAP_TWO_PIN: begin
        cap0_ld = cap0_ld | in0_rise;
        cap1_ld = in1_rise;
      end
      CAP_PULSE: begin
        cap0_ld = cap0_ld | in0_rise;
        cap1_ld = in0_fall & arm_q;
        if (in0_rise)      arm_d = 1'b1;
        else if (in0_fall) arm_d = 1'b0;
        else               arm_d = arm_q;
      end
      CAP_NEIGHBOUR: begin
        cap0_ld = cap0_ld | nb_rise;
        cap1_ld = nb_fall;
      end
      default: ;
    endcase
  end

  always_comb begin
    cap0_d = cap0_ld ? count : cap0_q;
    cap1_d = cap1_ld ? count : cap1_q;
    irq_d  = (mode == CAP_PULSE) ? in0_fall : in0_rise;
    inv_req = (tog_on_cap1 & cap1_ld) | (tog_on_match & match_evt);
    ff_d   = ff_q ^ inv_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap0_q <= '0;
      cap1_q <= '0;
      arm_q  <= 1'b0;
      ff_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cap0_q <= cap0_d;
      cap1_q <= cap1_d;
      arm_q  <= arm_d;
      ff_q   <= ff_d;
      irq_q  <= irq_d;
    end
  end

  assign cap0   = cap0_q;
  assign cap1   = cap1_q;
  assign ff_out = ff_q;
  assign irq    = irq_q;
endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int AW    = 4,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr_en,
  output logic [BYTE_W-1:0] rdata,
  output mode_t             mode,
  output logic              run,
  output logic [CNT_W-1:0]  cmp,
  output logic              sw_cap,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  cap0,
  input  logic [CNT_W-1:0]  cap1
);
  localparam int NB     = CNT_W / BYTE_W;
  localparam int A_MODE = 0;
  localparam int A_RUN  = 1;
  localparam int A_CMP  = 2;
  localparam int A_CNT  = A_CMP + NB;
  localparam int A_CAP0 = A_CNT + NB;
  localparam int A_CAP1 = A_CAP0 + NB;

  mode_t            mode_q, mode_d;
  logic             run_q, run_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             mode_wr;

  assign mode_wr = wr_en && (addr == AW'(A_MODE));
  assign sw_cap  = mode_wr && !wdata[5];

  always_comb begin
    mode_d = mode_q;
    run_d  = run_q;
    cmp_d  = cmp_q;
    if (mode_wr) begin
      mode_d          = mode_t'(wdata);
      mode_d.sw_cap_n = 1'b1;
    end
    if (wr_en && (addr == AW'(A_RUN))) run_d = wdata[0];
    for (int i = 0; i < NB; i++) begin
      if (wr_en && (addr == AW'(A_CMP + i))) cmp_d[i*BYTE_W +: BYTE_W] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= mode_t'(MODE_RESET);
      run_q  <= 1'b0;
      cmp_q  <= '0;
    end else begin
      mode_q <= mode_d;
      run_q  <= run_d;
      cmp_q  <= cmp_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(A_MODE)) rdata = mode_q;
    if (addr == AW'(A_RUN))  rdata = {{(BYTE_W-1){1'b0}}, run_q};
    for (int i = 0; i < NB; i++) begin
      if (addr == AW'(A_CMP + i))  rdata = cmp_q[i*BYTE_W +: BYTE_W];
      if (addr == AW'(A_CNT + i))  rdata = count[i*BYTE_W +: BYTE_W];
      if (addr == AW'(A_CAP0 + i)) rdata = cap0[i*BYTE_W +: BYTE_W];
      if (addr == AW'(A_CAP1 + i)) rdata = cap1[i*BYTE_W +: BYTE_W];
    end
  end

  assign mode = mode_q;
  assign run  = run_q;
  assign cmp  = cmp_q;
endmodule

// File: rtl/edge_capture_timer.sv
`timescale 1ns/1ps
module edge_capture_timer
  import tmr_pkg::*;
#(
  parameter int AW          = 4,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr_en,
  output logic [BYTE_W-1:0] rdata,
  input  logic              ext_in0,
  input  logic              ext_in1,
  input  logic              nbr_trig,
  input  logic              tick_div1,
  input  logic              tick_div4,
  input  logic              tick_div16,
  output logic              ff_out,
  output logic              match_pulse,
  output logic              ext_irq
);
  mode_t            mode;
  logic             run;
  logic [CNT_W-1:0] cmp;
  logic             sw_cap;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cap0, cap1;
  logic             cap1_ld;
  logic             match_evt;
  logic             in0_lvl, in0_rise, in0_fall;
  logic             in1_lvl, in1_rise, in1_fall;
  logic             nb_lvl, nb_rise, nb_fall;

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_in0 (
    .clk(clk), .rst_n(rst_n), .async_in(ext_in0),
    .level(in0_lvl), .rise(in0_rise), .fall(in0_fall)
  );
  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_in1 (
    .clk(clk), .rst_n(rst_n), .async_in(ext_in1),
    .level(in1_lvl), .rise(in1_rise), .fall(in1_fall)
  );
  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_nb (
    .clk(clk), .rst_n(rst_n), .async_in(nbr_trig),
    .level(nb_lvl), .rise(nb_rise), .fall(nb_fall)
  );

  tmr_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .mode(mode), .run(run), .cmp(cmp), .sw_cap(sw_cap),
    .count(count), .cap0(cap0), .cap1(cap1)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run), .src(mode.clk_src),
    .clr_on_match(mode.clr_on_match), .cmp(cmp),
    .tick_div1(tick_div1), .tick_div4(tick_div4), .tick_div16(tick_div16),
    .ext0_rise(in0_rise), .count(count), .match_evt(match_evt),
    .match_pulse(match_pulse)
  );

  tmr_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .mode(mode.cap_mode),
    .tog_on_cap1(mode.tog_on_cap1), .tog_on_match(mode.tog_on_match),
    .sw_cap(sw_cap), .count(count),
    .in0_rise(in0_rise), .in0_fall(in0_fall), .in1_rise(in1_rise),
    .nb_rise(nb_rise), .nb_fall(nb_fall), .match_evt(match_evt),
    .cap0(cap0), .cap1(cap1), .cap1_ld(cap1_ld), .ff_out(ff_out), .irq(ext_irq)
  );
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
module tmr_checker #(
  parameter int AW    = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    addr,
  input logic [7:0]       rdata,
  input logic             run,
  input logic             clr_on_match,
  input logic             tog_on_cap1,
  input logic             tog_on_match,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cap1,
  input logic             cap1_ld,
  input logic             match_pulse,
  input logic             ff_out
);
  p_swbit_reads_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0) |-> rdata[5]);

  p_stopped_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == $past(count)));

  p_clear_on_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_pulse && $past(clr_on_match)) |-> (count == '0));

  p_freerun_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_pulse && !$past(clr_on_match)) |-> (count == $past(count) + CNT_W'(1)));

  p_cap1_holds_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap1_ld |=> (cap1 == $past(count)));

  p_toggle_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ff_out) |-> (($past(cap1_ld) && $past(tog_on_cap1)) ||
                          (match_pulse && $past(tog_on_match))));
endmodule

bind edge_capture_timer tmr_checker #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rdata(rdata), .run(run),
  .clr_on_match(mode.clr_on_match), .tog_on_cap1(mode.tog_on_cap1),
  .tog_on_match(mode.tog_on_match), .count(count), .cap1(cap1),
  .cap1_ld(cap1_ld), .match_pulse(match_pulse), .ff_out(ff_out)
);

// File: tb/tb_edge_capture_timer.sv
`timescale 1ns/1ps
module tb_edge_capture_timer;
  logic       clk;
  logic       rst_n;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic       wr_en;
  logic [7:0] rdata;
  logic       ext_in0, ext_in1, nbr_trig;
  logic       tick_div1, tick_div4, tick_div16;
  logic       ff_out, match_pulse, ext_irq;

  int n_checks = 0;
  int n_fail   = 0;
  int irq_cnt  = 0;
  bit done     = 0;

  edge_capture_timer dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .ext_in0(ext_in0), .ext_in1(ext_in1), .nbr_trig(nbr_trig),
    .tick_div1(tick_div1), .tick_div4(tick_div4), .tick_div16(tick_div16),
    .ff_out(ff_out), .match_pulse(match_pulse), .ext_irq(ext_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) if (ext_irq) irq_cnt++;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; addr = '0; wdata = '0; wr_en = 1'b0;
    ext_in0 = 0; ext_in1 = 0; nbr_trig = 0;
    tick_div1 = 0; tick_div4 = 0; tick_div16 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    irq_cnt = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a + 4'd1, hi);
    v = {hi, lo};
  endtask

  task automatic tick1(input int n);
    @(negedge clk);
    tick_div1 = 1'b1;
    repeat (n) @(negedge clk);
    tick_div1 = 1'b0;
  endtask

  task automatic set_pin(ref logic pin, input logic v);
    @(negedge clk);
    pin = v;
    repeat (5) @(negedge clk);
  endtask

  // R1: reset values and bit 5 readback
  task automatic t_reset();
    logic [7:0] b; logic [15:0] v;
    do_reset();
    rd(4'd0, b);  check("R1 mode reset", b, 8'h20);
    rd(4'd1, b);  check("R1 run reset", b, 0);
    rd16(4'd4, v); check("R1 count reset", v, 0);
    rd16(4'd6, v); check("R1 cap0 reset", v, 0);
    rd16(4'd8, v); check("R1 cap1 reset", v, 0);
    check("R1 ff reset", ff_out, 0);
    wr(4'd0, 8'h01);
    rd(4'd0, b);  check("R1 bit5 reads one", b, 8'h21);
  endtask

  // R2/R3: source selection and run gating
  task automatic t_sources();
    logic [15:0] v;
    do_reset();
    wr(4'd2, 8'hFF); wr(4'd3, 8'hFF);
    wr(4'd0, 8'h21); wr(4'd1, 8'h01);
    tick1(10);
    rd16(4'd4, v); check("R2 div1 count", v, 10);
    @(negedge clk); tick_div4 = 1; tick_div16 = 1;
    repeat (6) @(negedge clk); tick_div4 = 0; tick_div16 = 0;
    rd16(4'd4, v); check("R2 unselected ticks ignored", v, 10);
    wr(4'd0, 8'h22);
    @(negedge clk); tick_div4 = 1; tick_div1 = 1;
    repeat (5) @(negedge clk); tick_div4 = 0; tick_div1 = 0;
    rd16(4'd4, v); check("R2 div4 count", v, 15);
    wr(4'd0, 8'h23);
    @(negedge clk); tick_div16 = 1;
    repeat (3) @(negedge clk); tick_div16 = 0;
    rd16(4'd4, v); check("R2 div16 count", v, 18);
    wr(4'd1, 8'h00);
    wr(4'd0, 8'h21);
    tick1(7);
    rd16(4'd4, v); check("R3 stopped count holds", v, 18);
  endtask

  // R2 external source, R9/R12 in capture mode 00
  task automatic t_ext_clock();
    logic [15:0] v;
    do_reset();
    wr(4'd2, 8'hFF); wr(4'd3, 8'hFF);
    wr(4'd0, 8'h20); wr(4'd1, 8'h01);
    for (int i = 0; i < 3; i++) begin
      set_pin(ext_in0, 1'b1);
      set_pin(ext_in0, 1'b0);
    end
    rd16(4'd4, v); check("R2 ext0 edge count", v, 3);
    check("R9 irq on rises in mode 00", irq_cnt, 3);
    set_pin(ext_in1, 1'b1); set_pin(ext_in1, 1'b0);
    rd16(4'd6, v); check("R12 cap0 untouched", v, 0);
    rd16(4'd8, v); check("R12 cap1 untouched", v, 0);
  endtask

  // R4/R5: clear on match, period cmp+1
  task automatic t_match_clear();
    logic [7:0] b;
    do_reset();
    wr(4'd2, 8'd5); wr(4'd3, 8'd0);
    wr(4'd0, 8'h25); wr(4'd1, 8'h01);
    @(negedge clk); addr = 4'd4; tick_div1 = 1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      #1 b = rdata;
      check("R5 match pulse timing", match_pulse, (k % 6) == 0);
      if (k % 6 == 0) check("R4 count cleared at match", b, 0);
      else            check("R4 count value", b, k % 6);
    end
    tick_div1 = 0;
  endtask

  // R5: free-running match
  task automatic t_match_free();
    logic [7:0] b;
    do_reset();
    wr(4'd2, 8'd3); wr(4'd3, 8'd0);
    wr(4'd0, 8'h21); wr(4'd1, 8'h01);
    @(negedge clk); addr = 4'd4; tick_div1 = 1;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      #1 b = rdata;
      check("R5 free-run match", match_pulse, k == 4);
      if (k == 4) check("R5 count passes compare", b, 4);
    end
    tick_div1 = 0;
  endtask

  // R6: two-pin rising captures
  task automatic t_mode01();
    logic [15:0] v;
    do_reset();
    wr(4'd2, 8'hFF); wr(4'd3, 8'hFF);
    wr(4'd0, 8'h29); wr(4'd1, 8'h01);
    tick1(10);
    set_pin(ext_in0, 1'b1);
    rd16(4'd6, v); check("R6 cap0 on in0 rise", v, 10);
    tick1(5);
    set_pin(ext_in1, 1'b1);
    rd16(4'd8, v); check("R6 cap1 on in1 rise", v, 15);
    tick1(5);
    set_pin(ext_in1, 1'b0);
    set_pin(ext_in0, 1'b0);
    rd16(4'd8, v); check("R6 in1 fall ignored", v, 15);
    rd16(4'd6, v); check("R6 in0 fall ignored", v, 10);
    check("R9 irq once on rise", irq_cnt, 1);
  endtask

  // R7/R9: pulse width
  task automatic t_mode10();
    logic [15:0] v;
    do_reset();
    wr(4'd2, 8'hFF); wr(4'd3, 8'hFF);
    wr(4'd0, 8'h31); wr(4'd1, 8'h01);
    tick1(7);
    set_pin(ext_in0, 1'b1);
    rd16(4'd6, v); check("R7 cap0 on rise", v, 7);
    check("R9 no irq on rise in mode 10", irq_cnt, 0);
    tick1(5);
    set_pin(ext_in0, 1'b0);
    rd16(4'd8, v); check("R7 cap1 on fall", v, 12);
    check("R9 irq on fall in mode 10", irq_cnt, 1);
    tick1(3);
    set_pin(ext_in1, 1'b1); set_pin(ext_in1, 1'b0);
    rd16(4'd8, v); check("R7 in1 ignored", v, 12);
    rd16(4'd6, v); check("R7 in1 leaves cap0", v, 7);
  endtask

  // R8: neighbour trigger
  task automatic t_mode11();
    logic [15:0] v;
    do_reset();
    wr(4'd2, 8'hFF); wr(4'd3, 8'hFF);
    wr(4'd0, 8'h39); wr(4'd1, 8'h01);
    tick1(3);
    set_pin(nbr_trig, 1'b1);
    rd16(4'd6, v); check("R8 cap0 on trigger rise", v, 3);
    tick1(6);
    set_pin(nbr_trig, 1'b0);
    rd16(4'd8, v); check("R8 cap1 on trigger fall", v, 9);
    tick1(2);
    set_pin(ext_in0, 1'b1); set_pin(ext_in0, 1'b0);
    rd16(4'd6, v); check("R8 in0 edges ignored", v, 3);
    rd16(4'd8, v); check("R8 in0 fall ignored", v, 9);
    check("R9 irq on rise in mode 11", irq_cnt, 1);
  endtask

  // R10: software capture
  task automatic t_swcap();
    logic [15:0] v; logic [7:0] b;
    do_reset();
    wr(4'd2, 8'hFF); wr(4'd3, 8'hFF);
    wr(4'd0, 8'h21); wr(4'd1, 8'h01);
    tick1(42);
    wr(4'd0, 8'h01);
    rd16(4'd6, v); check("R10 sw capture", v, 42);
    rd(4'd0, b);   check("R10 mode after sw write", b, 8'h21);
    tick1(4);
    wr(4'd0, 8'h21);
    rd16(4'd6, v); check("R10 write one no capture", v, 42);
  endtask

  // R11: toggle output
  task automatic t_toggle();
    do_reset();
    wr(4'd2, 8'hFF); wr(4'd3, 8'hFF);
    wr(4'd0, 8'h29); wr(4'd1, 8'h01);
    set_pin(ext_in1, 1'b1); set_pin(ext_in1, 1'b0);
    check("R11 no invert when disabled", ff_out, 0);
    wr(4'd0, 8'hA9);
    set_pin(ext_in1, 1'b1); set_pin(ext_in1, 1'b0);
    check("R11 invert on cap1 load", ff_out, 1);
    set_pin(ext_in1, 1'b1); set_pin(ext_in1, 1'b0);
    check("R11 second invert", ff_out, 0);
    do_reset();
    wr(4'd2, 8'd2); wr(4'd3, 8'd0);
    wr(4'd0, 8'h65); wr(4'd1, 8'h01);
    @(negedge clk); tick_div1 = 1;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      check("R11 invert on match", ff_out, (k / 3) % 2);
    end
    tick_div1 = 0;
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_sources();
    t_ext_clock();
    t_match_clear();
    t_match_free();
    t_mode01();
    t_mode10();
    t_mode11();
    t_swcap();
    t_toggle();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule